// File: doc/BRIEF.md
# Windowed Multiply-Accumulate Unit

This block multiplies two 16-bit signed operands and adds the product into a 40-bit accumulator. The product is sign-extended to 40 bits before the add. The sum wraps modulo 2^40. A sticky overflow flag records any signed overflow until the next clear. Software-side logic never sees the whole accumulator at once. It sees a 16-bit window through two byte ports, a high port and a low port. A registered 2-bit window select N maps the low port to byte N and the high port to byte N+1. Byte 0 is bits 7..0 and byte 4 is bits 39..32. With N = 2, the window shows bits 31..16, which is the integer-aligned half of a 16-bit fixed-point fractional result. The lower fraction bytes stay hidden.

Each cycle, a priority decoder turns the strobes into one action:
- `ACT_CLEAR` zeroes the accumulator and the overflow flag.
- `ACT_MAC` adds the product.
- `ACT_POKE` replaces the bytes mapped to the written ports.
- `ACT_IDLE` holds the accumulator.

The priority order is clear, then accumulate, then port write, then idle. Any action can follow any other on the next cycle. The window register is a second piece of state. It loads on its write strobe and otherwise holds. Both port reads are combinational views of the current accumulator at the current window.

Top module: `mac_window_unit`

## Requirements
- R1: After reset the accumulator is zero, the overflow flag is 0 and the window select is 00.
- R2: When `acc_go` is high and `acc_clr` is low, the next clock edge adds the signed 16x16 product, sign-extended to 40 bits, to the accumulator. With no strobe high, the accumulator holds.
- R3: With window select N, `rd_lo` shows accumulator byte N and `rd_hi` shows byte N+1. So 00 gives bytes 1:0, 01 gives bytes 2:1, 10 gives bytes 3:2 and 11 gives bytes 4:3.
- R4: `acc_clr` zeroes all 40 bits and the overflow flag on the next edge, and it wins over `acc_go` in the same cycle.
- R5: `lo_wr` replaces only byte N with `wr_lo`, and `hi_wr` replaces only byte N+1 with `wr_hi`. All other bytes are unchanged. Both ports may be written in one cycle.
- R6: When a port write and an accumulate happen in the same cycle, the accumulate result is stored and the port write is discarded.
- R7: The sum wraps modulo 2^40. `ovf` is set when an accumulate causes signed 40-bit overflow, and it stays set until a clear.
- R8: The window select loads `win_val` when `win_wr` is high and holds otherwise. The port reads follow the new window in the cycle after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| acc_go | input | 1 | Accumulate strobe |
| acc_clr | input | 1 | Clear strobe |
| win_wr | input | 1 | Window select load strobe |
| win_val | input | 2 | New window select value |
| hi_wr | input | 1 | High port byte write strobe |
| lo_wr | input | 1 | Low port byte write strobe |
| wr_hi | input | 8 | High port write data |
| wr_lo | input | 8 | Low port write data |
| rd_hi | output | 8 | High port read: byte N+1 |
| rd_lo | output | 8 | Low port read: byte N |
| ovf | output | 1 | Sticky signed overflow flag |

## Verification
The accumulator is only visible through the window, so a wrong byte inside it stays hidden until the window covers that byte. To close that gap, the bench walks the window across the low, middle and top pairs after every accumulate, and any corrupt byte shows within three cycles. A wrong action priority shows up in the first cycle after the conflicting strobes: a poked byte appears where the sum should be, or a clear leaves a nonzero value behind. A lost or spurious overflow bit is visible on `ovf` one edge after the add that wraps.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_MAC   = 2'd2,
        ACT_POKE  = 2'd3
    } mac_act_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acc_go,
    input  logic     acc_clr,
    input  logic     hi_wr,
    input  logic     lo_wr,
    output mac_act_e act
);
    // priority: clear > accumulate > byte poke > idle
    always_comb begin
        if (acc_clr)             act = ACT_CLEAR;
        else if (acc_go)         act = ACT_MAC;
        else if (hi_wr || lo_wr) act = ACT_POKE;
        else                     act = ACT_IDLE;
    end

    assert_clear_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |-> act == ACT_CLEAR);
    assert_mac_over_poke_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && !acc_clr) |-> act == ACT_MAC);
endmodule

// File: rtl/mac_window.sv
module mac_window #(
    parameter int NBYTES = 5,
    localparam int ACCW = 8 * NBYTES,
    localparam int WINW = $clog2(NBYTES - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_wr,
    input  logic [WINW-1:0] win_val,
    input  logic [ACCW-1:0] acc,
    output logic [WINW-1:0] win,
    output logic [7:0]      rd_hi,
    output logic [7:0]      rd_lo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      win <= '0;
        else if (win_wr) win <= win_val;
    end

    always_comb begin
        rd_lo = acc[int'(win) * 8 +: 8];
        rd_hi = acc[int'(win) * 8 + 8 +: 8];
    end

    assert_win_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> $stable(win));
    assert_win_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr |=> win == $past(win_val));
endmodule

// File: rtl/mac_acc.sv
module mac_acc
    import mac_pkg::*;
#(
    parameter int NBYTES = 5,
    localparam int ACCW = 8 * NBYTES,
    localparam int WINW = $clog2(NBYTES - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mac_act_e        act,
    input  logic [ACCW-1:0] prod_ext,
    input  logic [WINW-1:0] win,
    input  logic            hi_wr,
    input  logic            lo_wr,
    input  logic [7:0]      wr_hi,
    input  logic [7:0]      wr_lo,
    output logic [ACCW-1:0] acc,
    output logic            ovf
);
    logic [ACCW-1:0] sum;
    logic [ACCW-1:0] poked;
    logic            ovf_now;

    assign sum     = acc + prod_ext;
    assign ovf_now = (acc[ACCW-1] == prod_ext[ACCW-1]) && (sum[ACCW-1] != acc[ACCW-1]);

    // per-byte replacement for the port write path
    always_comb begin
        poked = acc;
        for (int i = 0; i < NBYTES; i++) begin
            if (lo_wr && int'(win) == i)     poked[i*8 +: 8] = wr_lo;
            if (hi_wr && int'(win) + 1 == i) poked[i*8 +: 8] = wr_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            ovf <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR: begin
                    acc <= '0;
                    ovf <= 1'b0;
                end
                ACT_MAC: begin
                    acc <= sum;
                    ovf <= ovf | ovf_now;
                end
                ACT_POKE: acc <= poked;
                ACT_IDLE: acc <= acc;
            endcase
        end
    end

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_CLEAR |=> (acc == '0 && !ovf));
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && act != ACT_CLEAR) |=> ovf);
    assert_mac_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_MAC |=> acc == $past(acc) + $past(prod_ext));
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_IDLE |=> $stable(acc) && $stable(ovf));
    assert_poke_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_POKE |=> $stable(ovf));
endmodule

// File: rtl/mac_window_unit.sv
module mac_window_unit
    import mac_pkg::*;
#(
    parameter int OPW    = 16,
    parameter int NBYTES = 5,
    localparam int ACCW  = 8 * NBYTES,
    localparam int PRODW = 2 * OPW,
    localparam int WINW  = $clog2(NBYTES - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OPW-1:0]  op_a,
    input  logic [OPW-1:0]  op_b,
    input  logic            acc_go,
    input  logic            acc_clr,
    input  logic            win_wr,
    input  logic [WINW-1:0] win_val,
    input  logic            hi_wr,
    input  logic            lo_wr,
    input  logic [7:0]      wr_hi,
    input  logic [7:0]      wr_lo,
    output logic [7:0]      rd_hi,
    output logic [7:0]      rd_lo,
    output logic            ovf
);
    mac_act_e        act;
    logic [WINW-1:0] win;
    logic [ACCW-1:0] acc;
    logic [PRODW-1:0] prod;
    logic [ACCW-1:0] prod_ext;

    assign prod     = PRODW'($signed(op_a) * $signed(op_b));
    assign prod_ext = {{(ACCW-PRODW){prod[PRODW-1]}}, prod};

    mac_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_go(acc_go), .acc_clr(acc_clr),
        .hi_wr(hi_wr), .lo_wr(lo_wr), .act(act)
    );

    mac_window #(.NBYTES(NBYTES)) u_win (
        .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .win_val(win_val),
        .acc(acc), .win(win), .rd_hi(rd_hi), .rd_lo(rd_lo)
    );

    mac_acc #(.NBYTES(NBYTES)) u_acc (
        .clk(clk), .rst_n(rst_n), .act(act), .prod_ext(prod_ext), .win(win),
        .hi_wr(hi_wr), .lo_wr(lo_wr), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .acc(acc), .ovf(ovf)
    );
endmodule

// File: tb/test_mac_window_unit.sv
module test_mac_window_unit;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        acc_go = 0, acc_clr = 0, win_wr = 0, hi_wr = 0, lo_wr = 0;
    logic [1:0]  win_val = '0;
    logic [7:0]  wr_hi = '0, wr_lo = '0;
    logic [7:0]  rd_hi, rd_lo;
    logic        ovf;

    int total = 0;
    int bad = 0;
    logic [39:0] model = '0;
    logic        mflag = 1'b0;

    always #2.5 clk = ~clk;

    mac_window_unit i_mac_window_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .acc_go(acc_go),
        .acc_clr(acc_clr), .win_wr(win_wr), .win_val(win_val), .hi_wr(hi_wr),
        .lo_wr(lo_wr), .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_hi(rd_hi),
        .rd_lo(rd_lo), .ovf(ovf)
    );

    localparam logic [31:0] VEC [0:7] = '{
        32'h0003_0005, 32'hFFFF_0002, 32'h8000_8000, 32'h7FFF_7FFF,
        32'h8000_7FFF, 32'h1234_FEDC, 32'h0000_ABCD, 32'hFFFF_FFFF
    };

    task automatic check(input bit ok, input string req, input logic [39:0] got, input logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic set_win(input logic [1:0] w);
        win_wr = 1; win_val = w;
        @(negedge clk);
        win_wr = 0;
    endtask

    task automatic read_acc(output logic [39:0] v);
        set_win(2'd0); v[15:0]  = {rd_hi, rd_lo};
        set_win(2'd2); v[31:16] = {rd_hi, rd_lo};
        set_win(2'd3); v[39:32] = rd_hi;
    endtask

    function automatic logic [39:0] sext(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] p;
        p = $signed(a) * $signed(b);
        return {{8{p[31]}}, p};
    endfunction

    task automatic model_mac(input logic [15:0] a, input logic [15:0] b);
        logic [39:0] pe, s;
        pe = sext(a, b);
        s = model + pe;
        if (model[39] == pe[39] && s[39] != model[39]) mflag = 1'b1;
        model = s;
    endtask

    task automatic do_mac(input logic [15:0] a, input logic [15:0] b);
        op_a = a; op_b = b; acc_go = 1;
        @(negedge clk);
        acc_go = 0;
        model_mac(a, b);
    endtask

    task automatic poke(input logic [1:0] w, input logic hw, input logic [7:0] hd,
                        input logic lw, input logic [7:0] ld);
        set_win(w);
        hi_wr = hw; wr_hi = hd; lo_wr = lw; wr_lo = ld;
        @(negedge clk);
        hi_wr = 0; lo_wr = 0;
        if (lw) model[int'(w)*8 +: 8] = ld;
        if (hw) model[int'(w)*8 + 8 +: 8] = hd;
    endtask

    initial begin
        #(5ns * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [39:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state, window 00 shows bytes 1:0
        check({rd_hi, rd_lo} == 16'h0 && ovf == 0, "R1 reset", {rd_hi, rd_lo}, 0);
        rst_n = 1;
        @(negedge clk);
        read_acc(v);
        check(v == 40'h0, "R1 acc zero", v, 0);
        check(ovf == 1'b0, "R1 ovf zero", ovf, 0);

        // R2: table walk of signed products
        foreach (VEC[i]) begin
            do_mac(VEC[i][31:16], VEC[i][15:0]);
            read_acc(v);
            check(v == model, "R2 accumulate", v, model);
        end
        check(ovf == mflag, "R7 ovf after table", ovf, mflag);

        // R2: no strobe holds
        repeat (3) @(negedge clk);
        read_acc(v);
        check(v == model, "R2 idle hold", v, model);

        // R3: window 01 shows bytes 2:1
        set_win(2'd1);
        check({rd_hi, rd_lo} == model[23:8], "R3 window 01", {rd_hi, rd_lo}, model[23:8]);

        // R8: no load keeps window despite win_val change
        win_val = 2'd3;
        @(negedge clk);
        check({rd_hi, rd_lo} == model[23:8], "R8 window hold", {rd_hi, rd_lo}, model[23:8]);

        // R4: clear beats accumulate
        op_a = 16'h0100; op_b = 16'h0100; acc_go = 1; acc_clr = 1;
        @(negedge clk);
        acc_go = 0; acc_clr = 0;
        model = '0; mflag = 0;
        read_acc(v);
        check(v == 40'h0 && ovf == 0, "R4 clear priority", v, 0);

        // R5: byte writes touch only the mapped bytes
        poke(2'd1, 1, 8'hA5, 1, 8'h3C);
        read_acc(v);
        check(v == 40'h00_00A5_3C00, "R5 window 01 poke", v, 40'h00_00A5_3C00);
        poke(2'd3, 1, 8'h11, 0, 8'hEE);
        read_acc(v);
        check(v == model, "R5 high only", v, model);

        // R6: accumulate beats port write
        set_win(2'd0);
        op_a = 16'h0002; op_b = 16'h0003; acc_go = 1;
        hi_wr = 1; wr_hi = 8'hFF; lo_wr = 1; wr_lo = 8'hFF;
        @(negedge clk);
        acc_go = 0; hi_wr = 0; lo_wr = 0;
        model_mac(16'h0002, 16'h0003);
        read_acc(v);
        check(v == model, "R6 mac over poke", v, model);

        // R7: wrap at top of signed range
        poke(2'd3, 1, 8'h7F, 1, 8'hFF);
        poke(2'd1, 1, 8'hFF, 1, 8'hFF);
        poke(2'd0, 0, 8'h00, 1, 8'hFF);
        read_acc(v);
        check(v == 40'h7F_FFFF_FFFF, "R5 build max", v, 40'h7F_FFFF_FFFF);
        check(ovf == 0, "R5 poke leaves ovf", ovf, 0);
        do_mac(16'h0001, 16'h0001);
        read_acc(v);
        check(v == 40'h80_0000_0000, "R7 wrap", v, 40'h80_0000_0000);
        check(ovf == 1, "R7 ovf set", ovf, 1);
        do_mac(16'h0000, 16'h0005);
        check(ovf == 1, "R7 ovf sticky", ovf, 1);
        acc_clr = 1;
        @(negedge clk);
        acc_clr = 0;
        check(ovf == 0, "R4 clear ovf", ovf, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule